// File: doc/BRIEF.md
# Framed Serial Word Receiver

This block collects words from a serial stream that comes with its own bit clock, a mode line and a framing line. Bits are clocked into a 12-bit shift register, but only after the framing line has risen. Serial clock pulses that come before that edge are ignored. Each frame holds an 8-bit data word and then 4 parity bits, and the block discards the parity bits. When the twelfth bit arrives, the block latches the data word, raises a ready interrupt and stops counting until the next framing edge.

The block keeps the mode line's level as it stood at the most recent serial clock rising edge. During a valid sample period a low level means BCD data follows and a high level means numeric data follows. The host reads this flag as a status bit.

A host on a small parallel bus reads the data word and a status location. The host also writes a one-bit source-select latch, which chooses between the live serial inputs and a self-test copy of the same four signals. All serial-side inputs are resynchronised to the system clock. For this reason the serial bit clock must run at no more than a quarter of the system clock rate.

Top module: `ser_word_rx`

## Requirements
- R1: A synchronous active-high reset clears the ready interrupt, the overrun bit, the mode flag, the data word and the source latch, so the live inputs are selected and the status location reads 0.
- R2: Serial clock rising edges that come before any framing rising edge shift nothing and never raise the ready interrupt.
- R3: After a framing rising edge, the twelfth serial clock rising edge raises `readyIrq`. Reading address 0 then returns the first eight bits received, with the first bit received as bit 7. The four bits that follow are dropped.
- R4: Status bit 2 holds the level of the selected mode line at the most recent selected serial clock rising edge.
- R5: A falling edge of `wrN` while `csN` is low and `addr` is 1 loads `wrSel` into the source latch, which reads back as status bit 3. When the latch is 1 the self-test inputs drive the receiver and activity on the live inputs has no effect. When it is 0 the live inputs drive the receiver.
- R6: A write strobe with `csN` high, or with `addr` at 0, leaves the source latch unchanged.
- R7: `busOe` is high only while both `csN` and `rdN` are low. `rdData` is 0 whenever `busOe` is low.
- R8: A falling edge of `rdN` with `csN` low and `addr` at 0 clears the ready interrupt and the overrun bit. A read of address 1 clears neither.
- R9: If a frame completes while the ready interrupt is still high, status bit 1 (overrun) is set and address 0 then holds the newer word.
- R10: A framing rising edge in the middle of a frame restarts the bit count from zero. After a frame completes, serial clock edges are ignored until the next framing rising edge.
- R11: Status bit 0 shows the ready interrupt. Status bits 7..4 read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| extData | input | 1 | Live serial data |
| extClk | input | 1 | Live serial bit clock |
| extMode | input | 1 | Live mode line (low = BCD, high = numeric) |
| extFrame | input | 1 | Live framing line; a rising edge starts a frame |
| tstData | input | 1 | Self-test serial data |
| tstClk | input | 1 | Self-test serial bit clock |
| tstMode | input | 1 | Self-test mode line |
| tstFrame | input | 1 | Self-test framing line |
| csN | input | 1 | Host address select, active low |
| rdN | input | 1 | Host read strobe, active low |
| wrN | input | 1 | Host write strobe, active low |
| addr | input | 1 | Host location: 0 data word, 1 status/control |
| wrSel | input | 1 | Write data bit 0 for the source latch |
| rdData | output | 8 | Host read data |
| busOe | output | 1 | Read driver enable |
| readyIrq | output | 1 | Word-ready interrupt |

## Verification
The receiver is driven with several frame patterns. Clock pulses sent with no framing edge show whether counting is gated. Asymmetric words such as 0xA5 followed by non-zero parity show the bit order and the truncation of the parity bits. A frame restarted after five bits tells a counter that resets on the framing edge from one that keeps counting. Two back-to-back frames with no read in between exercise overrun and replacement of the word. The same frames are also sent on the unselected source while the other one is selected, which shows that the source latch really isolates each set of inputs. The mode level is changed between frames to show it is captured per clock.

// File: rtl/swr_pkg.sv
package swr_pkg;
  // host bus locations
  localparam logic ADDR_DATA = 1'b0;
  localparam logic ADDR_STAT = 1'b1;

  // status bit positions
  localparam int STAT_READY = 0;
  localparam int STAT_OVR   = 1;
  localparam int STAT_MODE  = 2;
  localparam int STAT_SRC   = 3;

  // synchroniser lanes
  localparam int LANE_DATA  = 0;
  localparam int LANE_CLK   = 1;
  localparam int LANE_MODE  = 2;
  localparam int LANE_FRAME = 3;
  localparam int LANES      = 4;

  typedef struct packed {
    logic shiftEn;
    logic takeWord;
    logic captureMode;
    logic loadCtrl;
  } swrStrobe_t;
endpackage

// File: rtl/swr_datapath.sv
module swr_datapath
  import swr_pkg::*;
#(
  parameter int WORD_BITS   = 8,
  parameter int PAR_BITS    = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [LANES-1:0]     extLanes,
  input  logic [LANES-1:0]     tstLanes,
  input  logic                 wrSel,
  input  swrStrobe_t           strb,
  output logic                 clkRise,
  output logic                 frameRise,
  output logic [WORD_BITS-1:0] wordQ,
  output logic                 modeQ,
  output logic                 srcSel
);
  localparam int FRAME_BITS = WORD_BITS + PAR_BITS;

  logic [LANES-1:0] selLanes;
  logic [LANES-1:0] syncStg [SYNC_STAGES];
  logic [LANES-1:0] syncOut;
  logic             clkPrev;
  logic             framePrev;
  logic [FRAME_BITS-1:0] shiftQ;
  logic [FRAME_BITS-1:0] shiftNext;

  // source selection happens ahead of the synchronisers
  assign selLanes = srcSel ? tstLanes : extLanes;

  genvar gs;
  generate
    for (gs = 0; gs < SYNC_STAGES; gs++) begin : g_sync
      if (gs == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) syncStg[gs] <= '0;
          else     syncStg[gs] <= selLanes;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) syncStg[gs] <= '0;
          else     syncStg[gs] <= syncStg[gs-1];
        end
      end
    end
  endgenerate

  assign syncOut = syncStg[SYNC_STAGES-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      clkPrev   <= 1'b0;
      framePrev <= 1'b0;
    end else begin
      clkPrev   <= syncOut[LANE_CLK];
      framePrev <= syncOut[LANE_FRAME];
    end
  end

  assign clkRise   = syncOut[LANE_CLK]   & ~clkPrev;
  assign frameRise = syncOut[LANE_FRAME] & ~framePrev;

  assign shiftNext = {shiftQ[FRAME_BITS-2:0], syncOut[LANE_DATA]};

  always_ff @(posedge clk) begin
    if (rst) begin
      shiftQ <= '0;
      wordQ  <= '0;
      modeQ  <= 1'b0;
      srcSel <= 1'b0;
    end else begin
      if (strb.shiftEn)     shiftQ <= shiftNext;
      if (strb.takeWord)    wordQ  <= shiftNext[FRAME_BITS-1 -: WORD_BITS];
      if (strb.captureMode) modeQ  <= syncOut[LANE_MODE];
      if (strb.loadCtrl)    srcSel <= wrSel;
    end
  end

  // R5
  src_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !strb.loadCtrl |=> $stable(srcSel));
  // R4
  mode_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !strb.captureMode |=> $stable(modeQ));
  // R3
  word_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !strb.takeWord |=> $stable(wordQ));
endmodule

// File: rtl/swr_control.sv
module swr_control
  import swr_pkg::*;
#(
  parameter int WORD_BITS = 8,
  parameter int PAR_BITS  = 4
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       clkRise,
  input  logic       frameRise,
  input  logic       csN,
  input  logic       rdN,
  input  logic       wrN,
  input  logic       addr,
  output swrStrobe_t strb,
  output logic       readyQ,
  output logic       ovrQ
);
  localparam int FRAME_BITS = WORD_BITS + PAR_BITS;
  localparam int CNT_W      = $clog2(FRAME_BITS + 1);

  logic [CNT_W-1:0] bitCnt;
  logic             armed;
  logic             rdPrev;
  logic             wrPrev;
  logic             shiftEn;
  logic             lastBit;
  logic             clrReady;
  logic             loadCtrl;

  // a framing edge wins over a coincident clock edge
  assign shiftEn  = armed & clkRise & ~frameRise;
  assign lastBit  = shiftEn & (bitCnt == CNT_W'(FRAME_BITS - 1));
  assign clrReady = rdPrev & ~rdN & ~csN & (addr == ADDR_DATA);
  assign loadCtrl = wrPrev & ~wrN & ~csN & (addr == ADDR_STAT);

  always_comb begin
    strb             = '0;
    strb.shiftEn     = shiftEn;
    strb.takeWord    = lastBit;
    strb.captureMode = clkRise;
    strb.loadCtrl    = loadCtrl;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdPrev <= 1'b1;
      wrPrev <= 1'b1;
    end else begin
      rdPrev <= rdN;
      wrPrev <= wrN;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      armed  <= 1'b0;
      bitCnt <= '0;
    end else if (frameRise) begin
      armed  <= 1'b1;
      bitCnt <= '0;
    end else if (shiftEn) begin
      if (lastBit) begin
        armed  <= 1'b0;
        bitCnt <= '0;
      end else begin
        bitCnt <= bitCnt + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      readyQ <= 1'b0;
      ovrQ   <= 1'b0;
    end else if (lastBit) begin
      readyQ <= 1'b1;
      ovrQ   <= clrReady ? 1'b0 : (ovrQ | readyQ);
    end else if (clrReady) begin
      readyQ <= 1'b0;
      ovrQ   <= 1'b0;
    end
  end

  // R8
  ready_hold_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(readyQ) |-> $past(~rdN & ~csN & (addr == ADDR_DATA)));
  // R9
  ovr_needs_ready_chk: assert property (@(posedge clk) disable iff (rst)
    ovrQ |-> readyQ);
  // R3
  cnt_range_chk: assert property (@(posedge clk) disable iff (rst)
    bitCnt < CNT_W'(FRAME_BITS));
  // R10
  idle_cnt_chk: assert property (@(posedge clk) disable iff (rst)
    !armed |-> bitCnt == '0);
endmodule

// File: rtl/ser_word_rx.sv
module ser_word_rx
  import swr_pkg::*;
#(
  parameter int WORD_BITS   = 8,
  parameter int PAR_BITS    = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 extData,
  input  logic                 extClk,
  input  logic                 extMode,
  input  logic                 extFrame,
  input  logic                 tstData,
  input  logic                 tstClk,
  input  logic                 tstMode,
  input  logic                 tstFrame,
  input  logic                 csN,
  input  logic                 rdN,
  input  logic                 wrN,
  input  logic                 addr,
  input  logic                 wrSel,
  output logic [WORD_BITS-1:0] rdData,
  output logic                 busOe,
  output logic                 readyIrq
);
  swrStrobe_t           strb;
  logic                 clkRise;
  logic                 frameRise;
  logic [WORD_BITS-1:0] wordQ;
  logic                 modeQ;
  logic                 srcSel;
  logic                 readyQ;
  logic                 ovrQ;
  logic [LANES-1:0]     extLanes;
  logic [LANES-1:0]     tstLanes;
  logic [WORD_BITS-1:0] statWord;

  always_comb begin
    extLanes             = '0;
    extLanes[LANE_DATA]  = extData;
    extLanes[LANE_CLK]   = extClk;
    extLanes[LANE_MODE]  = extMode;
    extLanes[LANE_FRAME] = extFrame;
    tstLanes             = '0;
    tstLanes[LANE_DATA]  = tstData;
    tstLanes[LANE_CLK]   = tstClk;
    tstLanes[LANE_MODE]  = tstMode;
    tstLanes[LANE_FRAME] = tstFrame;
  end

  swr_datapath #(
    .WORD_BITS(WORD_BITS), .PAR_BITS(PAR_BITS), .SYNC_STAGES(SYNC_STAGES)
  ) u_dp (
    .clk(clk), .rst(rst), .extLanes(extLanes), .tstLanes(tstLanes),
    .wrSel(wrSel), .strb(strb), .clkRise(clkRise), .frameRise(frameRise),
    .wordQ(wordQ), .modeQ(modeQ), .srcSel(srcSel)
  );

  swr_control #(
    .WORD_BITS(WORD_BITS), .PAR_BITS(PAR_BITS)
  ) u_ctl (
    .clk(clk), .rst(rst), .clkRise(clkRise), .frameRise(frameRise),
    .csN(csN), .rdN(rdN), .wrN(wrN), .addr(addr), .strb(strb),
    .readyQ(readyQ), .ovrQ(ovrQ)
  );

  always_comb begin
    statWord             = '0;
    statWord[STAT_READY] = readyQ;
    statWord[STAT_OVR]   = ovrQ;
    statWord[STAT_MODE]  = modeQ;
    statWord[STAT_SRC]   = srcSel;
  end

  assign busOe    = ~csN & ~rdN;
  assign rdData   = busOe ? ((addr == ADDR_STAT) ? statWord : wordQ) : '0;
  assign readyIrq = readyQ;

  // R7
  bus_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !busOe |-> rdData == '0);
endmodule

// File: tb/tb_ser_word_rx.sv
module tb_ser_word_rx;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic extData = 0, extClk = 0, extMode = 0, extFrame = 0;
  logic tstData = 0, tstClk = 0, tstMode = 0, tstFrame = 0;
  logic csN = 1, rdN = 1, wrN = 1, addr = 0, wrSel = 0;
  logic [7:0] rdData;
  logic busOe, readyIrq;

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 0;
  logic [7:0] expQ[$];
  event monEv;

  always #5 clk = ~clk;

  ser_word_rx dut (
    .clk(clk), .rst(rst), .extData(extData), .extClk(extClk),
    .extMode(extMode), .extFrame(extFrame), .tstData(tstData),
    .tstClk(tstClk), .tstMode(tstMode), .tstFrame(tstFrame),
    .csN(csN), .rdN(rdN), .wrN(wrN), .addr(addr), .wrSel(wrSel),
    .rdData(rdData), .busOe(busOe), .readyIrq(readyIrq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic setLines(input bit src, input logic d, input logic c,
                          input logic m, input logic f);
    if (src) begin tstData = d; tstClk = c; tstMode = m; tstFrame = f; end
    else     begin extData = d; extClk = c; extMode = m; extFrame = f; end
  endtask

  // framing rising edge, then n bits MSB-first from a 12-bit pattern
  task automatic sendBits(input bit src, input logic [11:0] pat, input int n,
                          input logic m, input bit withFrame);
    if (withFrame) begin
      setLines(src, 0, 0, m, 0); tick(4);
      setLines(src, 0, 0, m, 1); tick(4);
    end
    for (int i = 0; i < n; i++) begin
      setLines(src, pat[11-i], 0, m, withFrame); tick(4);
      setLines(src, pat[11-i], 1, m, withFrame); tick(4);
      setLines(src, pat[11-i], 0, m, withFrame);
    end
    tick(4);
  endtask

  // driver: sends a whole frame and pushes the expected word
  task automatic sendFrame(input bit src, input logic [7:0] w, input logic [3:0] par,
                           input logic m);
    sendBits(src, {w, par}, 12, m, 1'b1);
    setLines(src, 0, 0, m, 0);
    expQ.push_back(w);
    tick(2);
  endtask

  task automatic readWord();
    addr = 0; csN = 0; rdN = 0;
    tick(1);
    -> monEv;
    tick(1);
    rdN = 1; csN = 1;
    tick(2);
  endtask

  task automatic readStat(output logic [7:0] v);
    addr = 1; csN = 0; rdN = 0;
    tick(1);
    v = rdData;
    rdN = 1; csN = 1;
    tick(2);
  endtask

  task automatic hostWrite(input logic a, input logic b, input logic cs);
    addr = a; wrSel = b; csN = cs;
    tick(1);
    wrN = 0; tick(2);
    wrN = 1; tick(1);
    csN = 1; tick(1);
  endtask

  // monitor: compares each data read against the scoreboard queue
  initial begin
    forever begin
      @(monEv);
      if (expQ.size() == 0) chk("R3 unexpected read", {24'b0, rdData}, 32'hFFFF_FFFF);
      else chk("R3 data word", {24'b0, rdData}, {24'b0, expQ.pop_front()});
    end
  end

  initial begin
    #(200000 * 10);
    if (!done) begin
      nFails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  [TB] %0d tests run, %0d failed", nChecks + 1, nFails);
      $finish;
    end
  end

  initial begin
    logic [7:0] st;
    tick(3);
    rst = 0;
    tick(2);
    // R1 reset state
    chk("R1 ready after reset", readyIrq, 0);
    readStat(st);
    chk("R1 status after reset", st, 8'h00);
    // R7 idle bus
    chk("R7 busOe idle", busOe, 0);
    chk("R7 rdData idle", rdData, 0);

    // R2 clocks without framing edge
    sendBits(0, 12'hFFF, 12, 0, 1'b0);
    chk("R2 no ready without frame", readyIrq, 0);

    // R3 / R4 / R11 main frame, mode high
    sendFrame(0, 8'hA5, 4'hA, 1);
    chk("R3 ready after 12 bits", readyIrq, 1);
    readStat(st);
    chk("R11 status ready bit", st[0], 1);
    chk("R4 mode high captured", st[2], 1);
    chk("R11 upper status zero", st[7:4], 0);
    chk("R8 status read keeps ready", readyIrq, 1);
    readWord();
    chk("R8 data read clears ready", readyIrq, 0);

    // R10 restart mid-frame, mode low
    sendBits(0, 12'hFFF, 5, 0, 1'b1);
    chk("R10 partial frame not ready", readyIrq, 0);
    sendFrame(0, 8'h3C, 4'h5, 0);
    chk("R10 restarted frame ready", readyIrq, 1);
    readStat(st);
    chk("R4 mode low captured", st[2], 0);
    readWord();
    sendBits(0, 12'hFFF, 12, 0, 1'b0);
    chk("R10 clocks after frame ignored", readyIrq, 0);

    // R9 overrun
    sendFrame(0, 8'h11, 4'hF, 0);
    sendFrame(0, 8'h22, 4'h0, 0);
    void'(expQ.pop_front());
    readStat(st);
    chk("R9 overrun set", st[1], 1);
    readWord();
    readStat(st);
    chk("R8 overrun cleared by data read", st[1:0], 2'b00);

    // R5 select self-test source
    hostWrite(1, 1, 0);
    readStat(st);
    chk("R5 source bit set", st[3], 1);
    sendBits(0, {8'h77, 4'h0}, 12, 1, 1'b1);
    extFrame = 0; tick(2);
    chk("R5 live inputs ignored", readyIrq, 0);
    sendFrame(1, 8'hC3, 4'h6, 1);
    chk("R5 self-test frame ready", readyIrq, 1);
    readStat(st);
    chk("R5 self-test mode captured", st[2], 1);
    readWord();

    // R6 ignored writes
    hostWrite(0, 0, 0);
    readStat(st);
    chk("R6 addr0 write ignored", st[3], 1);
    hostWrite(1, 0, 1);
    readStat(st);
    chk("R6 deselected write ignored", st[3], 1);
    hostWrite(1, 0, 0);
    readStat(st);
    chk("R5 source bit cleared", st[3], 0);
    sendFrame(0, 8'h5A, 4'h3, 0);
    chk("R5 live source restored", readyIrq, 1);
    readWord();

    // R7 select without read strobe
    csN = 0; addr = 1; tick(1);
    chk("R7 busOe needs rdN", busOe, 0);
    chk("R7 rdData quiet", rdData, 0);
    csN = 1; tick(1);
    chk("R3 scoreboard drained", expQ.size(), 0);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end
endmodule